// File: doc/BRIEF.md
# Cascadable priority interrupt controller

This block gathers eight level-sensitive interrupt request lines, ranks them by a fixed priority and raises a single interrupt output toward a processor. Software reaches it through two byte-wide addresses: a command address and a data address. After reset it stays silent until software writes a short setup sequence. That sequence supplies the vector base, the cascade link information and the mode bits. From then on, data-address writes load the mask register.

The processor answers the interrupt with two acknowledge pulses. The first pulse latches the winning level into the in-service register. The second pulse returns an 8-bit vector formed from the vector base and the level. An in-service level holds off equal and lower levels until software releases it with a specific end-of-interrupt command, unless automatic release was chosen at setup.

Several controllers can be chained. A master names the inputs that carry a subordinate controller. When such an input wins, the master puts the level number on its link output and leaves the vector to the subordinate. A subordinate answers acknowledge pulses only when the link input matches its own identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the in-service register is empty, command-address reads return the request register, and `irq_out` stays low until the setup sequence completes, even if an unmasked request is present.
- R2: A command write with bit 4 set starts setup. It clears the in-service register, automatic release and the read selection, and it leaves the mask unchanged. The following data writes are taken in this order: the base byte; then the link byte, unless bit 1 of the start byte was set; then the mode byte, if bit 0 of the start byte was set. Once setup is complete, data writes load the mask again.
- R3: Outside setup, a data write loads the mask register and a data read returns it. A set mask bit keeps that input from raising `irq_out`.
- R4: The request register bit of an input follows that input one clock later while the input is not in service. The first acknowledge pulse clears the bit of the winning level, and the bit stays clear while that level is in service.
- R5: Priority is fixed, with input 0 the highest. `irq_out` is high only when an unmasked request has a strictly higher priority than every in-service level.
- R6: The first acknowledge pulse sets the in-service bit of the winning level. One clock after the second pulse, `vec_valid` is high for one cycle and `vec_out` equals {base byte bits 7:3, level}.
- R7: A command write of 0x0A makes command-address reads return the request register, and 0x0B makes them return the in-service register. The choice lasts until it is changed.
- R8: A command write of 0x60+n (bits 7:5 = 011, bits 4:3 = 00) clears only in-service bit n.
- R9: When bit 1 of the mode byte is set, the second acknowledge pulse clears the in-service bit of the acknowledged level.
- R10: If no request qualifies at the first acknowledge pulse, the vector carries level 7 and in-service bit 7 is not set.
- R11: In a master (`slave_mode` low), if the winning level has its link-byte bit set, `link_out` carries that level between the two pulses and no vector is produced.
- R12: In a subordinate (`slave_mode` high), acknowledge pulses are ignored unless `link_in` equals link-byte bits 2:0, and `link_out` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | High selects the subordinate role |
| irq_in | input | 8 | Level-sensitive request lines |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address on bus_addr |
| ack_pulse | input | 1 | Acknowledge pulse, one cycle each |
| link_in | input | 3 | Cascade level seen by a subordinate |
| link_out | output | 3 | Cascade level driven by a master |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid for one cycle |
| vec_out | output | 8 | Acknowledged vector |

## Verification
The acknowledge path is driven with several request patterns. A single unmasked input checks the vector arithmetic. Three requests at once show which input wins. A higher request that arrives while a lower level is in service shows nesting, and a lower request that arrives in the same situation shows that it is held off. A request that goes away before the acknowledge shows the level-7 fallback, and an input that carries a cascade link shows that the vector is withheld and the link level is driven. The mode variants are also covered: setup with and without the link and mode bytes, automatic release against explicit release, and a subordinate whose link identity does not match against one whose identity matches. Each variant is followed by a readback of the request or in-service register, so a bit that was wrongly set or cleared is visible at the ports.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    // Setup progress after a start command
    typedef enum logic [1:0] {
        CFG_RUN,
        CFG_WAIT_BASE,
        CFG_WAIT_LINK,
        CFG_WAIT_MODE
    } cfg_step_e;

    localparam int CMD_START_BIT = 4;
    localparam int CMD_SEL_BIT   = 3;
    localparam logic [2:0] CMD_REL_CODE = 3'b011;
endpackage

// File: rtl/pic8_prio.sv
// Finds the lowest-numbered set bit (highest priority)
module pic8_prio #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/pic8_cfg.sv
// Command/data decoding, setup sequence, mask and mode storage
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int NUM_IN = 8,
    localparam int LVL_W = $clog2(NUM_IN),
    localparam int BASE_W = 8 - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              ready,
    output logic [BASE_W-1:0] base_hi,
    output logic [NUM_IN-1:0] link_map,
    output logic              auto_rel,
    output logic [NUM_IN-1:0] mask,
    output logic              show_svc,
    output logic              rel_valid,
    output logic [LVL_W-1:0]  rel_lvl,
    output logic              setup_start
);
    typedef struct packed {
        cfg_step_e         step;
        logic              need_link;
        logic              need_mode;
        logic              ready;
        logic [BASE_W-1:0] base_hi;
        logic [NUM_IN-1:0] link_map;
        logic              auto_rel;
        logic [NUM_IN-1:0] mask;
        logic              show_svc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d       = cfg_q;
        rel_valid   = 1'b0;
        rel_lvl     = bus_wdata[LVL_W-1:0];
        setup_start = 1'b0;
        if (bus_wr && !bus_addr) begin
            if (bus_wdata[CMD_START_BIT]) begin
                setup_start     = 1'b1;
                cfg_d.step      = CFG_WAIT_BASE;
                cfg_d.need_link = !bus_wdata[1];
                cfg_d.need_mode = bus_wdata[0];
                cfg_d.ready     = 1'b0;
                cfg_d.auto_rel  = 1'b0;
                cfg_d.show_svc  = 1'b0;
            end else if (bus_wdata[CMD_SEL_BIT]) begin
                if (bus_wdata[1]) cfg_d.show_svc = bus_wdata[0];
            end else if (bus_wdata[7:5] == CMD_REL_CODE) begin
                rel_valid = 1'b1;
            end
        end
        if (bus_wr && bus_addr) begin
            unique case (cfg_q.step)
                CFG_RUN: cfg_d.mask = bus_wdata[NUM_IN-1:0];
                CFG_WAIT_BASE: begin
                    cfg_d.base_hi = bus_wdata[7:LVL_W];
                    if (cfg_q.need_link)      cfg_d.step = CFG_WAIT_LINK;
                    else if (cfg_q.need_mode) cfg_d.step = CFG_WAIT_MODE;
                    else begin
                        cfg_d.step  = CFG_RUN;
                        cfg_d.ready = 1'b1;
                    end
                end
                CFG_WAIT_LINK: begin
                    cfg_d.link_map = bus_wdata[NUM_IN-1:0];
                    if (cfg_q.need_mode) cfg_d.step = CFG_WAIT_MODE;
                    else begin
                        cfg_d.step  = CFG_RUN;
                        cfg_d.ready = 1'b1;
                    end
                end
                CFG_WAIT_MODE: begin
                    cfg_d.auto_rel = bus_wdata[1];
                    cfg_d.step     = CFG_RUN;
                    cfg_d.ready    = 1'b1;
                end
                default: cfg_d.step = CFG_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q          <= '0;
            cfg_q.step     <= CFG_RUN;
            cfg_q.mask     <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ready    = cfg_q.ready;
    assign base_hi  = cfg_q.base_hi;
    assign link_map = cfg_q.link_map;
    assign auto_rel = cfg_q.auto_rel;
    assign mask     = cfg_q.mask;
    assign show_svc = cfg_q.show_svc;
endmodule

// File: rtl/pic8_ctrl.sv
// Top: request/in-service tracking, priority decision, acknowledge
module pic8_ctrl #(
    parameter int NUM_IN = 8,
    localparam int LVL_W = $clog2(NUM_IN),
    localparam int BASE_W = 8 - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ack_pulse,
    input  logic [LVL_W-1:0]  link_in,
    output logic [LVL_W-1:0]  link_out,
    output logic              irq_out,
    output logic              vec_valid,
    output logic [7:0]        vec_out
);
    typedef struct packed {
        logic [NUM_IN-1:0] req;
        logic [NUM_IN-1:0] svc;
        logic              phase;
        logic              spur;
        logic [LVL_W-1:0]  lvl;
        logic [7:0]        vec;
        logic              vecv;
    } core_t;

    core_t core_d, core_q;

    logic              ready, auto_rel, show_svc, rel_valid, setup_start;
    logic [BASE_W-1:0] base_hi;
    logic [NUM_IN-1:0] link_map, mask;
    logic [LVL_W-1:0]  rel_lvl;

    pic8_cfg #(.NUM_IN(NUM_IN)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ready      (ready),
        .base_hi    (base_hi),
        .link_map   (link_map),
        .auto_rel   (auto_rel),
        .mask       (mask),
        .show_svc   (show_svc),
        .rel_valid  (rel_valid),
        .rel_lvl    (rel_lvl),
        .setup_start(setup_start)
    );

    logic [NUM_IN-1:0] pend;
    logic              pend_any, svc_any, want;
    logic [LVL_W-1:0]  pend_idx, svc_idx;

    assign pend = core_q.req & ~mask;

    pic8_prio #(.N(NUM_IN)) u_pend_prio (.req(pend), .any(pend_any), .idx(pend_idx));
    pic8_prio #(.N(NUM_IN)) u_svc_prio  (.req(core_q.svc), .any(svc_any), .idx(svc_idx));

    assign want = ready && pend_any && (!svc_any || (pend_idx < svc_idx));

    logic              ack_sel;
    logic [NUM_IN-1:0] set_m, clr_m;

    always_comb begin
        core_d      = core_q;
        core_d.vecv = 1'b0;
        set_m       = '0;
        clr_m       = '0;
        ack_sel     = ack_pulse && (!slave_mode || (link_in == link_map[LVL_W-1:0]));
        if (ack_sel && !core_q.phase) begin
            core_d.phase = 1'b1;
            if (want) begin
                core_d.lvl     = pend_idx;
                core_d.spur    = 1'b0;
                set_m[pend_idx] = 1'b1;
            end else begin
                core_d.lvl  = LVL_W'(NUM_IN - 1);
                core_d.spur = 1'b1;
            end
        end else if (ack_sel && core_q.phase) begin
            core_d.phase = 1'b0;
            if (slave_mode || !link_map[core_q.lvl]) begin
                core_d.vecv = 1'b1;
                core_d.vec  = {base_hi, core_q.lvl};
            end
            if (auto_rel && !core_q.spur) clr_m[core_q.lvl] = 1'b1;
        end
        if (rel_valid) clr_m[rel_lvl] = 1'b1;
        core_d.svc = (core_q.svc | set_m) & ~clr_m;
        core_d.req = ((irq_in & ~core_q.svc) | (core_q.req & core_q.svc)) & ~set_m;
        if (setup_start) begin
            core_d.svc   = '0;
            core_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign irq_out   = want;
    assign vec_valid = core_q.vecv;
    assign vec_out   = core_q.vec;
    assign link_out  = (!slave_mode && core_q.phase && link_map[core_q.lvl]) ? core_q.lvl : '0;
    assign bus_rdata = bus_addr ? 8'(mask) : (show_svc ? 8'(core_q.svc) : 8'(core_q.req));

    // plain views for the bound checker
    logic [NUM_IN-1:0] req_v, svc_v;
    logic              phase_v, spur_v;
    assign req_v   = core_q.req;
    assign svc_v   = core_q.svc;
    assign phase_v = core_q.phase;
    assign spur_v  = core_q.spur;
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
    parameter int NUM_IN = 8,
    localparam int LVL_W = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_pulse,
    input logic              slave_mode,
    input logic              irq_out,
    input logic              vec_valid,
    input logic [LVL_W-1:0]  link_out,
    input logic              ready,
    input logic [NUM_IN-1:0] req_v,
    input logic [NUM_IN-1:0] svc_v,
    input logic [NUM_IN-1:0] mask,
    input logic              rel_valid,
    input logic [LVL_W-1:0]  rel_lvl,
    input logic              phase_v,
    input logic              spur_v
);
    AST_SILENT_BEFORE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !irq_out); // R1

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((req_v & ~mask) != '0)); // R3

    AST_SVC_SET_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc_v & ~$past(svc_v)) != '0) |-> $past(ack_pulse)); // R6

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_pulse)); // R6

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rel_valid) |-> !svc_v[$past(rel_lvl)]); // R8

    AST_SPUR_NO_SVC7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_v && spur_v && !$past(phase_v) && !$past(rel_valid))
        |-> (svc_v[NUM_IN-1] == $past(svc_v[NUM_IN-1]))); // R10

    AST_SUB_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (link_out == '0)); // R12
endmodule

bind pic8_ctrl pic8_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_pulse (ack_pulse),
    .slave_mode(slave_mode),
    .irq_out   (irq_out),
    .vec_valid (vec_valid),
    .link_out  (link_out),
    .ready     (ready),
    .req_v     (req_v),
    .svc_v     (svc_v),
    .mask      (mask),
    .rel_valid (rel_valid),
    .rel_lvl   (rel_lvl),
    .phase_v   (phase_v),
    .spur_v    (spur_v)
);

// File: tb/sim_pic8_ctrl.sv
`timescale 1ns/1ps
module sim_pic8_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b0;
    logic [7:0] irq_in = '0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack_pulse = 1'b0;
    logic [2:0] link_in = '0;
    logic [2:0] link_out;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack_pulse(ack_pulse), .link_in(link_in),
        .link_out(link_out), .irq_out(irq_out), .vec_valid(vec_valid),
        .vec_out(vec_out)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk); ack_pulse = 1'b1;
        @(negedge clk); ack_pulse = 1'b0;
    endtask

    // driver: pushes the expected vector, then acknowledges
    task automatic ack_expect(input logic [7:0] v);
        exp_q.push_back(v);
        pulse(); pulse();
        tick(1);
    endtask

    task automatic ack_silent();
        pulse(); pulse();
        tick(1);
    endtask

    // monitor: compares vectors as they appear
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected vector got %02h expected none", vec_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_out !== e) begin
                    errors++;
                    $display("FAIL R6 vector got %02h expected %02h", vec_out, e);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(1, r); check("R1 mask", r, 8'hFF);
        rd(0, r); check("R1 request view", r, 8'h00);
        check("R1 irq", {7'd0, irq_out}, 8'h00);
        irq_in = 8'h08;
        wr(1, 8'h00);
        tick(1);
        check("R1 silent before setup", {7'd0, irq_out}, 8'h00);
        rd(0, r); check("R4 request follows", r, 8'h08);
        rd(1, r); check("R3 mask readback", r, 8'h00);
        // R2 full setup: base 0x20, link input 2, mode byte present
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        tick(1);
        check("R2 irq after setup", {7'd0, irq_out}, 8'h01);
        wr(1, 8'hFF);
        check("R3 all masked", {7'd0, irq_out}, 8'h00);
        wr(1, 8'hF7);
        check("R3 input 3 unmasked", {7'd0, irq_out}, 8'h01);
        wr(1, 8'h00);
        // R5 three requests, input 1 wins
        irq_in = 8'h2A;
        tick(1);
        ack_expect(8'h21);
        wr(0, 8'h0B); rd(0, r); check("R7 in-service view", r, 8'h02);
        wr(0, 8'h0A); rd(0, r); check("R4 held while in service", r, 8'h28);
        check("R5 lower held off", {7'd0, irq_out}, 8'h00);
        wr(0, 8'h61);
        tick(1);
        rd(0, r); check("R4 follows after release", r, 8'h2A);
        wr(0, 8'h0B); rd(0, r); check("R8 released", r, 8'h00);
        // R5 nesting
        irq_in = 8'h28;
        tick(1);
        ack_expect(8'h23);
        rd(0, r); check("R7 selection persists", r, 8'h08);
        irq_in = 8'h29;
        tick(1);
        check("R5 higher nests", {7'd0, irq_out}, 8'h01);
        ack_expect(8'h20);
        rd(0, r); check("R5 nested in service", r, 8'h09);
        wr(0, 8'h63); rd(0, r); check("R8 only level 3", r, 8'h01);
        wr(0, 8'h60); rd(0, r); check("R8 level 0", r, 8'h00);
        // R10 request withdrawn
        irq_in = 8'h20;
        tick(1);
        check("R10 request seen", {7'd0, irq_out}, 8'h01);
        irq_in = 8'h00;
        tick(1);
        ack_expect(8'h27);
        rd(0, r); check("R10 level 7 not in service", r, 8'h00);
        // R11 cascade input on master
        irq_in = 8'h04;
        tick(1);
        pulse();
        check("R11 link level", {5'd0, link_out}, 8'h02);
        pulse();
        tick(1);
        rd(0, r); check("R11 in service", r, 8'h04);
        wr(0, 8'h62);
        // R9 automatic release
        irq_in = 8'h10;
        tick(1);
        wr(0, 8'h11);
        rd(0, r); check("R2 setup selects request view", r, 8'h10);
        wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h03);
        rd(1, r); check("R2 mask unchanged", r, 8'h00);
        ack_expect(8'h24);
        wr(0, 8'h0B); rd(0, r); check("R9 auto released", r, 8'h00);
        irq_in = 8'h00;
        // R2 short setup: no link byte, no mode byte
        wr(0, 8'h12); wr(1, 8'h48);
        wr(1, 8'h5A); rd(1, r); check("R2 mask after short setup", r, 8'h5A);
        wr(1, 8'h00);
        irq_in = 8'h01;
        tick(1);
        ack_expect(8'h48);
        wr(0, 8'h0B); rd(0, r); check("R2 auto release cleared", r, 8'h01);
        wr(0, 8'h60);
        irq_in = 8'h00;
        // R12 subordinate role, identity 2, base 0x28
        slave_mode = 1'b1;
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h01);
        irq_in = 8'h40;
        link_in = 3'd3;
        tick(1);
        ack_silent();
        wr(0, 8'h0B); rd(0, r); check("R12 wrong identity ignored", r, 8'h00);
        check("R12 still requesting", {7'd0, irq_out}, 8'h01);
        link_in = 3'd2;
        ack_expect(8'h2E);
        rd(0, r); check("R12 matching identity served", r, 8'h40);
        check("R12 link quiet", {5'd0, link_out}, 8'h00);
        tick(2);
        check("R6 all vectors seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule